// File: doc/BRIEF.md
# Colour-Button Sequence Lock

This block is the controller of a push-button lock. A user first presses a start button and then presses three colour buttons (red, green, blue) in a fixed four-press order: red, blue, green, red. When the last press of that order is accepted, the block raises its unlock output for exactly one clock cycle and then drops back to idle.

Alongside the three colour lines, the block receives an any-button line. This line is high whenever at least one colour button is held. A press is counted once, on the clock where any-button goes from low to high, so a button held down across many clocks is one press. The button must be released before the next press can count. At that counting clock the colour lines must show exactly the colour that is expected next. Any other pattern sends the lock back to idle. Pressing start while a code is partly entered begins the code again from its first position.

All inputs are sampled on the rising clock edge. Reset is synchronous and active high. The unlock output comes straight from the state register, so it never glitches with the inputs.

Top module: `colour_lock`

## Requirements
- R1: With rst high at a clock edge, the lock goes to idle and unlock_o is 0 after that edge. The first press after reset must begin again from start.
- R2: In idle, start_i high moves the lock to the armed position. Colour presses in idle have no effect, so a full red, blue, green, red entry made without start never raises unlock_o.
- R3: unlock_o is 1 only in the open state. The open state is entered only from the third-step position. It lasts exactly one cycle, and the lock then returns to idle whatever the inputs are.
- R4: After start, four accepted presses in the order red, blue, green, red raise unlock_o in the cycle after the clock edge that samples the final red press.
- R5: A press is counted only at a clock where any_i is 1 and was 0 at the previous clock. Holding a button over several clocks counts as one press, and any_i must fall before the next press counts.
- R6: A counted press is correct only if the expected colour line is 1 and the other two are 0. Any other pattern returns the lock to idle. This includes a wrong colour, two colours at once, and no colour.
- R7: While entering the code, a clock with no counted press and start_i low leaves the position unchanged. This holds even when a colour line is high while any_i is low.
- R8: start_i high in any code-entry position (armed or after one to three correct presses) returns the lock to the armed position. Start wins over a press counted at the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start button |
| red_i | input | 1 | Red colour button |
| green_i | input | 1 | Green colour button |
| blue_i | input | 1 | Blue colour button |
| any_i | input | 1 | High while any colour button is held |
| unlock_o | output | 1 | One-cycle unlock pulse |

## Verification
A lock that took the wrong position has no way to show it until the final red press. At that press, unlock_o is either missing when it should pulse or present when it should stay low. The bench therefore ends every scenario with the rest of a full entry, so that a dropped restart, a double-counted held button, or a missed rejection turns into a wrong unlock_o value within a few cycles. The unlock pulse itself is checked again in the following cycle, so that an open state that lingers is caught at once.

// File: rtl/colour_lock_pkg.sv
package colour_lock_pkg;

  localparam int NUM_COLOURS = 3;
  localparam int COL_RED     = 0;
  localparam int COL_GREEN   = 1;
  localparam int COL_BLUE    = 2;

  typedef logic [NUM_COLOURS-1:0] colour_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ARMED = 3'd1,
    ST_GOT1  = 3'd2,
    ST_GOT2  = 3'd3,
    ST_GOT3  = 3'd4,
    ST_OPEN  = 3'd5
  } lock_state_t;

  // Colour expected at each code-entry position (red, blue, green, red).
  function automatic colour_t want_colour(lock_state_t s);
    colour_t c;
    c = '0;
    case (s)
      ST_ARMED: c[COL_RED]   = 1'b1;
      ST_GOT1:  c[COL_BLUE]  = 1'b1;
      ST_GOT2:  c[COL_GREEN] = 1'b1;
      ST_GOT3:  c[COL_RED]   = 1'b1;
      default:  c = '0;
    endcase
    return c;
  endfunction

  function automatic lock_state_t advance(lock_state_t s);
    lock_state_t n;
    case (s)
      ST_ARMED: n = ST_GOT1;
      ST_GOT1:  n = ST_GOT2;
      ST_GOT2:  n = ST_GOT3;
      ST_GOT3:  n = ST_OPEN;
      default:  n = ST_IDLE;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lock_press_detect.sv
module lock_press_detect (
  input  logic clk,
  input  logic rst,
  input  logic any_i,
  output logic press_o
);

  logic any_q;

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= any_i;
  end

  assign press_o = any_i & ~any_q;

  // R5: a press is a single-cycle event; a held button cannot repeat it
  assert_single_press_R5: assert property (@(posedge clk) disable iff (rst)
    press_o |=> !press_o);

endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import colour_lock_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  input  logic    press_i,
  input  colour_t colour_i,
  output logic    unlock_o
);

  lock_state_t state, state_nx;
  logic        in_code;

  assign in_code = (state == ST_ARMED) || (state == ST_GOT1) ||
                   (state == ST_GOT2)  || (state == ST_GOT3);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: if (start_i) state_nx = ST_ARMED;
      ST_OPEN: state_nx = ST_IDLE;
      ST_ARMED, ST_GOT1, ST_GOT2, ST_GOT3: begin
        if (start_i)
          state_nx = ST_ARMED;
        else if (press_i)
          state_nx = (colour_i == want_colour(state)) ? advance(state) : ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign unlock_o = (state == ST_OPEN);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && !unlock_o));

  assert_arm_from_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_i) |=> state == ST_ARMED);

  assert_idle_ignores_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !start_i) |=> state == ST_IDLE);

  assert_open_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    unlock_o |=> !unlock_o);

  assert_open_from_got3_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock_o) |-> $past(state) == ST_GOT3);

  assert_wrong_press_R6: assert property (@(posedge clk) disable iff (rst)
    (in_code && !start_i && press_i && colour_i != want_colour(state))
      |=> state == ST_IDLE);

  assert_hold_position_R7: assert property (@(posedge clk) disable iff (rst)
    (in_code && !start_i && !press_i) |=> $stable(state));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (in_code && start_i) |=> state == ST_ARMED);

endmodule

// File: rtl/colour_lock.sv
module colour_lock
  import colour_lock_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic red_i,
  input  logic green_i,
  input  logic blue_i,
  input  logic any_i,
  output logic unlock_o
);

  colour_t colours;
  logic    press;

  always_comb begin
    colours            = '0;
    colours[COL_RED]   = red_i;
    colours[COL_GREEN] = green_i;
    colours[COL_BLUE]  = blue_i;
  end

  lock_press_detect u_press (
    .clk     (clk),
    .rst     (rst),
    .any_i   (any_i),
    .press_o (press)
  );

  lock_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .press_i  (press),
    .colour_i (colours),
    .unlock_o (unlock_o)
  );

endmodule

// File: tb/colour_lock_tb.sv
module colour_lock_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, red_i = 1'b0, green_i = 1'b0, blue_i = 1'b0, any_i = 1'b0;
  logic unlock_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;  // 125 MHz

  colour_lock u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .red_i(red_i),
    .green_i(green_i), .blue_i(blue_i), .any_i(any_i), .unlock_o(unlock_o)
  );

  // Vector bits: {start, red, green, blue, any, expected unlock after the edge}
  localparam int NV = 63;
  localparam logic [5:0] VEC [0:NV-1] = '{
    // happy path: R2 arm, R4 full code, R3 single-cycle pulse
    6'b100000, 6'b000000, 6'b010010, 6'b000000, 6'b000110,
    6'b000000, 6'b001010, 6'b000000, 6'b010011, 6'b000000,
    // R5: held red counts once
    6'b100000, 6'b010010, 6'b010010, 6'b010010, 6'b000000,
    6'b000110, 6'b000000, 6'b001010, 6'b000000, 6'b010011,
    6'b000000,
    // R6: wrong colour returns to idle, later entry without start stays locked
    6'b100000, 6'b010010, 6'b000000, 6'b001010, 6'b000000,
    6'b000110, 6'b000000, 6'b001010, 6'b000000, 6'b010010,
    // R6: two colours at once rejected
    6'b100000, 6'b010110, 6'b000000, 6'b000110, 6'b000000,
    6'b001010, 6'b000000, 6'b010010,
    // R8: restart mid-entry
    6'b100000, 6'b010010, 6'b000000, 6'b000110, 6'b000000,
    6'b100000, 6'b010010, 6'b000000, 6'b000110, 6'b000000,
    6'b001010, 6'b000000, 6'b010011, 6'b000000,
    // R7: colour high with any low holds position
    6'b100000, 6'b010010, 6'b010000, 6'b000000, 6'b000110,
    6'b000000, 6'b001010, 6'b000000, 6'b010011, 6'b000000
  };

  localparam int VREQ [0:NV-1] = '{
    2,2,4,4,4,4,4,4,4,3,
    5,5,5,5,5,5,5,5,5,5,5,
    6,6,6,6,6,6,6,6,6,6,
    6,6,6,6,6,6,6,6,
    8,8,8,8,8,8,8,8,8,8,8,8,8,8,
    7,7,7,7,7,7,7,7,7,7
  };

  task automatic apply(input logic [5:0] v, input int req);
    {start_i, red_i, green_i, blue_i, any_i} = v[5:1];
    @(posedge clk);
    #1;
    n_checks++;
    if (unlock_o !== v[0]) begin
      n_fail++;
      $display("FAIL R%0d check %0d: unlock_o=%b expected %b", req, n_checks, unlock_o, v[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, unlock_o=%b expected completion", unlock_o);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (unlock_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: unlock_o=%b expected 0", unlock_o);
    end
    rst = 1'b0;

    for (int i = 0; i < NV; i++) apply(VEC[i], VREQ[i]);

    // R2: full entry without start is ignored in idle
    apply(6'b010010, 2); apply(6'b000000, 2); apply(6'b000110, 2);
    apply(6'b000000, 2); apply(6'b001010, 2); apply(6'b000000, 2);
    apply(6'b010010, 2); apply(6'b000000, 2);

    // R3: start held across the open state does not extend the pulse
    apply(6'b100000, 3); apply(6'b010010, 3); apply(6'b000000, 3);
    apply(6'b000110, 3); apply(6'b000000, 3); apply(6'b001010, 3);
    apply(6'b000000, 3); apply(6'b010011, 3); apply(6'b100000, 3);

    // R1: reset mid-entry discards progress
    apply(6'b100000, 1); apply(6'b010010, 1); apply(6'b000000, 1);
    apply(6'b000110, 1); apply(6'b000000, 1); apply(6'b001010, 1);
    apply(6'b000000, 1);
    rst = 1'b1;
    apply(6'b000000, 1);
    rst = 1'b0;
    apply(6'b010010, 1); apply(6'b000000, 1);

    // R6: press with no colour line high is rejected
    apply(6'b100000, 6); apply(6'b000010, 6); apply(6'b000000, 6);
    apply(6'b010010, 6); apply(6'b000000, 6); apply(6'b000110, 6);
    apply(6'b000000, 6); apply(6'b001010, 6); apply(6'b000000, 6);
    apply(6'b010010, 6);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule